// File: doc/BRIEF.md
# Strobed Key Matrix Scanner

This block scans a matrix of up to 32 keys arranged as four strobe rows and eight return columns. It drives four active-low strobe lines one after another. Each return line is pulled up outside the chip, so an idle column reads high, and a key closed on the active row pulls its column low. The return lines pass through a synchronizer. When a strobe pulse ends, the synchronized column state for that row is stored in that row's scan register. A low column is stored as 1, so a pressed key reads as 1.

The period of one full scan is a power-of-two number of clocks chosen by a 2-bit field, and the four strobes split that period into equal quarter slots. The host reads any of the four scan registers through a plain indexed read port. The block does no debouncing and does not resolve multiple keypresses. The host reads the registers two or three times in a row and filters the results in software.

Top module: `keyscan_matrix`

## Requirements
- R1: The strobes go active (low) in the fixed order 0, 1, 2, 3 and then repeat. At most one strobe is low at any time, and after the first clock following reset exactly one is low.
- R2: The period field sets the clocks per full scan: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. Each strobe stays low for one quarter of that count.
- R3: The column state is captured at the clock edge that ends strobe n and is written into scan register n. Bit k of a register holds return input k.
- R4: A return input held low while its row is strobed is stored as 1. An input left high is stored as 0.
- R5: A new value on the period field does not change the slot width of the scan in progress. It takes effect from the next strobe 0 slot.
- R6: While reset is asserted, all four strobes are high and every scan register reads 0. After release, scanning starts with strobe 0.
- R7: The read data output shows the scan register selected by the read index, without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_sel | input | 2 | Scan period field (32 << value clocks per scan) |
| ret_in | input | 8 | Pulled-up column return inputs, low when a key on the active row is pressed |
| strobe_n | output | 4 | Active-low row strobes |
| rd_idx | input | 2 | Index of the scan register to read |
| rd_data | output | 8 | Contents of the selected scan register, 1 = pressed |

## Verification
The sampling checks assume that a return input settles well within one strobe slot. In practice this means it follows the strobes through the external matrix and is stable before the two-stage synchronizer delay ends. The bench models the matrix as a combinational function of the strobe outputs and holds each key pattern fixed for more than two full scans before any read, so every register has been refreshed from a stable pattern. The period field is changed either while the bench waits for a fresh scan or deliberately in the middle of a scan. The strobe-sequencing assertions rely only on the latched period, so either timing is legal for them.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
   // width of the period select field used across the block
   localparam int unsigned SEL_W = 2;

   // largest shift the period field can request
   localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

   // convert a row index into an active-low one-hot strobe word
   function automatic logic [15:0] row_strobe_n(input int unsigned idx, input int unsigned rows);
      logic [15:0] v;
      v = '1;
      for (int unsigned i = 0; i < rows; i++) begin
         if (i == idx) v[i] = 1'b0;
      end
      return v;
   endfunction
endpackage

// File: rtl/ks_sync.sv
module ks_sync #(
   parameter int unsigned WIDTH      = 8,
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] pressed
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ks_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= ACTIVE_LOW ? '1 : '0;
      end else begin
         chain[0] <= raw_in;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_inv
         assign pressed = ~chain[STAGES-1];
      end else begin : g_pass
         assign pressed = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ks_timer.sv
module ks_timer
   import keyscan_pkg::*;
#(
   parameter int unsigned ROWS      = 4,
   parameter int unsigned BASE_LOG2 = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SEL_W-1:0]        period_sel,
   output logic [ROWS-1:0]         strobe_n,
   output logic                    sample_en,
   output logic [$clog2(ROWS)-1:0] sample_row
);
   localparam int unsigned RIDX_W    = $clog2(ROWS);
   localparam int unsigned SLOT_LOG2 = BASE_LOG2 - RIDX_W;
   localparam int unsigned POS_W     = SLOT_LOG2 + SEL_MAX;

   generate
      if ((1 << RIDX_W) != ROWS) begin : g_bad_rows
         $error("ks_timer: ROWS must be a power of two");
      end
      if (BASE_LOG2 < RIDX_W + 1) begin : g_bad_base
         $error("ks_timer: base period too short for the row count");
      end
   endgenerate

   logic              started;
   logic [POS_W-1:0]  pos;
   logic [RIDX_W-1:0] row;
   logic [SEL_W-1:0]  sel_cur;
   logic [POS_W:0]    slot_len;
   logic [POS_W-1:0]  last_pos;
   logic              slot_end;
   logic [RIDX_W-1:0] row_nxt;
   logic [15:0]       strobe_word;

   always_comb begin
      slot_len = (POS_W+1)'(1) << (SLOT_LOG2 + sel_cur);
      last_pos = POS_W'(slot_len - 1'b1);
      slot_end = started && (pos == last_pos);
      row_nxt  = row + 1'b1;
      strobe_word = row_strobe_n(int'(row_nxt), ROWS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= 1'b0;
         pos      <= '0;
         row      <= '0;
         sel_cur  <= '0;
         strobe_n <= '1;
      end else if (!started) begin
         started  <= 1'b1;
         pos      <= '0;
         row      <= '0;
         sel_cur  <= period_sel;
         strobe_n <= ROWS'(row_strobe_n(0, ROWS));
      end else if (slot_end) begin
         pos      <= '0;
         row      <= row_nxt;
         strobe_n <= strobe_word[ROWS-1:0];
         if (row == RIDX_W'(ROWS-1)) sel_cur <= period_sel;
      end else begin
         pos <= pos + 1'b1;
      end
   end

   assign sample_en  = slot_end;
   assign sample_row = row;

   // R1
   onehot_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~strobe_n));

   // R1
   strobe_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_end |=> strobe_n == {$past(strobe_n[ROWS-2:0]), $past(strobe_n[ROWS-1])});

   // R2
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !slot_end) |=> $stable(strobe_n));

   // R5
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !(slot_end && row == RIDX_W'(ROWS-1))) |=> $stable(sel_cur));
endmodule

// File: rtl/ks_regfile.sv
module ks_regfile #(
   parameter int unsigned ROWS = 4,
   parameter int unsigned COLS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(ROWS)-1:0] wr_row,
   input  logic [COLS-1:0]         wr_data,
   input  logic [$clog2(ROWS)-1:0] rd_idx,
   output logic [COLS-1:0]         rd_data
);
   localparam int unsigned RIDX_W = $clog2(ROWS);

   logic [COLS-1:0] regs [ROWS];

   generate
      for (genvar g = 0; g < ROWS; g++) begin : g_row
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs[g] <= '0;
            else if (wr_en && wr_row == RIDX_W'(g)) regs[g] <= wr_data;
         end

         // R3
         row_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_row == RIDX_W'(g)) |=> regs[g] == $past(wr_data));
      end
   endgenerate

   assign rd_data = regs[rd_idx];
endmodule

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
   import keyscan_pkg::*;
#(
   parameter int unsigned ROWS        = 4,
   parameter int unsigned COLS        = 8,
   parameter int unsigned BASE_LOG2   = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [SEL_W-1:0]        period_sel,
   input  logic [COLS-1:0]         ret_in,
   output logic [ROWS-1:0]         strobe_n,
   input  logic [$clog2(ROWS)-1:0] rd_idx,
   output logic [COLS-1:0]         rd_data
);
   localparam int unsigned RIDX_W = $clog2(ROWS);

   logic [COLS-1:0]   col_pressed;
   logic              sample_en;
   logic [RIDX_W-1:0] sample_row;

   ks_sync #(.WIDTH(COLS), .STAGES(SYNC_STAGES), .ACTIVE_LOW(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(ret_in), .pressed(col_pressed));

   ks_timer #(.ROWS(ROWS), .BASE_LOG2(BASE_LOG2)) u_timer (
      .clk(clk), .rst_n(rst_n), .period_sel(period_sel),
      .strobe_n(strobe_n), .sample_en(sample_en), .sample_row(sample_row));

   ks_regfile #(.ROWS(ROWS), .COLS(COLS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(sample_en), .wr_row(sample_row),
      .wr_data(col_pressed), .rd_idx(rd_idx), .rd_data(rd_data));

   // R3
   sample_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en |=> $rose(strobe_n[$past(sample_row)]));
endmodule

// File: tb/sim_keyscan_matrix.sv
module sim_keyscan_matrix;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] period_sel = 2'd0;
   logic [7:0] ret_in;
   logic [3:0] strobe_n;
   logic [1:0] rd_idx = 2'd0;
   logic [7:0] rd_data;
   logic [31:0] keys = 32'h0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   keyscan_matrix u0 (.clk(clk), .rst_n(rst_n), .period_sel(period_sel),
      .ret_in(ret_in), .strobe_n(strobe_n), .rd_idx(rd_idx), .rd_data(rd_data));

   // matrix model: a column reads low when any strobed row has its key closed
   always_comb begin
      for (int k = 0; k < 8; k++) begin
         ret_in[k] = 1'b1;
         for (int r = 0; r < 4; r++)
            if (!strobe_n[r] && keys[r*8+k]) ret_in[k] = 1'b0;
      end
   end

   // vector: {period field, key pattern (bit r*8+k = row r, column k)}
   localparam logic [33:0] VEC [6] = '{
      {2'd0, 32'h0000_0001},
      {2'd1, 32'h8000_0000},
      {2'd2, 32'h0102_0408},
      {2'd3, 32'hFFFF_FFFF},
      {2'd0, 32'hA55A_3CC3},
      {2'd1, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // wait for strobe r to fall, then count the clocks it stays low
   task automatic low_width(input int r, output int w);
      while (strobe_n[r] !== 1'b1) @(negedge clk);
      while (strobe_n[r] !== 1'b0) @(negedge clk);
      w = 0;
      while (strobe_n[r] === 1'b0) begin w++; @(negedge clk); end
   endtask

   function automatic int act_row(input logic [3:0] s);
      for (int i = 0; i < 4; i++) if (s == ~(4'b1 << i)) return i;
      return -1;
   endfunction

   initial begin
      int w, p, prev;
      @(negedge clk);
      // R6: reset state
      check("R6 strobes", 32'(strobe_n), 32'hF);
      for (int r = 0; r < 4; r++) begin
         rd_idx = 2'(r); #0; check("R6 reg", 32'(rd_data), 32'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 start row", 32'(strobe_n), 32'hE);

      // R1: order of strobes
      prev = act_row(strobe_n);
      for (int n = 0; n < 6; n++) begin
         while (act_row(strobe_n) == prev) @(negedge clk);
         check("R1 order", 32'(act_row(strobe_n)), 32'((prev + 1) % 4));
         prev = act_row(strobe_n);
      end

      // R2: width and period per field value
      for (int s = 0; s < 4; s++) begin
         period_sel = 2'(s);
         cyc(600);
         low_width(0, w);
         check("R2 width", 32'(w), 32'(8 << s));
         p = w;
         while (strobe_n[0] !== 1'b0) begin p++; @(negedge clk); end
         check("R2 period", 32'(p), 32'(32 << s));
      end

      // R3, R4, R7: vector table
      foreach (VEC[i]) begin
         period_sel = VEC[i][33:32];
         keys = VEC[i][31:0];
         cyc(2 * (32 << VEC[i][33:32]) + 300);
         for (int r = 0; r < 4; r++) begin
            rd_idx = 2'(r); #0;
            check("R3 R4 R7 row data", 32'(rd_data), 32'(keys[r*8 +: 8]));
         end
      end

      // R3: register for row 2 is updated only when strobe 2 ends
      period_sel = 2'd2;
      keys = 32'h0;
      cyc(600);
      while (strobe_n[2] !== 1'b0) @(negedge clk);
      keys = 32'h00FF_0000;
      rd_idx = 2'd2;
      cyc(4);
      check("R3 not yet sampled", 32'(rd_data), 32'h0);
      while (strobe_n[2] !== 1'b1) @(negedge clk);
      check("R3 sampled at rise", 32'(rd_data), 32'hFF);

      // R5: period change mid-scan
      keys = 32'h0;
      period_sel = 2'd0;
      cyc(600);
      while (strobe_n[0] !== 1'b0) @(negedge clk);
      cyc(3);
      period_sel = 2'd3;
      low_width(1, w);
      check("R5 current scan kept", 32'(w), 32'd8);
      low_width(0, w);
      check("R5 next scan new width", 32'(w), 32'd64);

      // R6: reset in the middle of a scan
      keys = 32'hFFFF_FFFF;
      cyc(600);
      rst_n = 1'b0;
      @(negedge clk);
      check("R6 strobes in reset", 32'(strobe_n), 32'hF);
      rd_idx = 2'd1; #0;
      check("R6 reg cleared", 32'(rd_data), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R6 restart row 0", 32'(strobe_n), 32'hE);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule